// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block gives several requesting agents atomic read-modify-write access to a small shared word-addressed memory. Each agent can issue four kinds of request: a plain load, a plain store, a load-linked, or a store-conditional. A load-linked returns the word and leaves a reservation for the issuing agent on that address. A later store-conditional from the same agent writes its data only if that reservation is still intact. It reports 1 on success and 0 on failure, so software can loop back and retry when it reads a zero.

Every agent holds at most one reservation, made of a valid bit and an address. A store from any other agent to the reserved address breaks the reservation. This includes a plain store that releases a lock and a successful store-conditional. Nothing else ages a reservation out, so it survives any amount of work done between the pair. Requests that arrive together are served one per cycle, and the lowest agent index goes first. The memory write strobe is brought out, so an observer can see that a failed store-conditional produces no write cycle.

Top module: `llsc_monitor`

## Requirements
- R1: Per cycle at most one request is accepted. The accepted request is the one from the valid agent with the lowest index, and every other valid agent sees req_ready low and keeps waiting.
- R2: The response comes one cycle after acceptance: rsp_valid is high for the accepted agent only. For a load or a load-linked, rsp_rdata holds the word stored at the address at the time of acceptance; for a store or a store-conditional it is 0.
- R3: Operation codes are 0 = load, 1 = store, 2 = load-linked and 3 = store-conditional. A plain store raises mem_wr_en in its acceptance cycle, with mem_wr_addr and mem_wr_data taken from the request, and the memory holds the new word from the next cycle on. Loads and load-linked requests never raise mem_wr_en.
- R4: A load-linked records a reservation for its agent on its address. A store-conditional to that address with the reservation intact writes memory, raises mem_wr_en, and returns rsp_status = 1.
- R5: A store-conditional fails when its agent has no valid reservation or the address differs from the reserved one. A failing store-conditional returns rsp_status = 0, leaves memory unchanged and keeps mem_wr_en low. rsp_status is 0 for every operation other than a store-conditional.
- R6: A plain store by another agent to the reserved address breaks the reservation, including a store of value 0. A store to a different address does not break it, and neither does a store by the holding agent itself.
- R7: A successful store-conditional breaks the reservations of all other agents on that address. When two agents issue a store-conditional together, the lower index succeeds and the other then fails.
- R8: Any store-conditional clears its own agent's reservation, whether it succeeds or fails, so a second store-conditional without a new load-linked fails.
- R9: A new load-linked replaces the agent's previous reservation. A store-conditional to the older address then fails.
- R10: A reservation stays valid for an unbounded time: idle cycles and loads by other agents do not clear it.
- R11: Reset clears every reservation and every memory word to 0, and holds rsp_valid and mem_wr_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_AGENTS | Request valid, one bit per agent |
| req_ready | output | N_AGENTS | Request accepted this cycle, one bit per agent |
| req_op | input | 2*N_AGENTS | Operation code per agent (0 load, 1 store, 2 load-linked, 3 store-conditional) |
| req_addr | input | ADDR_W*N_AGENTS | Word address per agent |
| req_wdata | input | DATA_W*N_AGENTS | Write data per agent |
| rsp_valid | output | N_AGENTS | Response valid, one cycle after acceptance |
| rsp_rdata | output | DATA_W | Read data of the response |
| rsp_status | output | 1 | Store-conditional result: 1 success, 0 failure |
| mem_wr_en | output | 1 | Memory write cycle strobe |
| mem_wr_addr | output | ADDR_W | Address of the memory write |
| mem_wr_data | output | DATA_W | Data of the memory write |

## Verification
The bench builds the block with three agents, a 4-bit address and 16-bit data. Three agents are enough to have a holder, an interfering agent and a bystander in one sequence. They also let two store-conditionals collide in one cycle while a third agent's reservation sits on another address. With sixteen words the sequences use separate addresses for separate reservations, so an unrelated store can be shown to leave a reservation intact. Read-back loads then show that failed store-conditionals left their addresses unchanged.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LL    = 2'd2,
        OP_SC    = 2'd3
    } llsc_op_e;

endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
    parameter int N_AGENTS = 3,
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic [N_AGENTS-1:0] req_valid,
    output logic [N_AGENTS-1:0] grant,
    output logic [IDX_W-1:0]    grant_idx,
    output logic                grant_any
);

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int i = N_AGENTS - 1; i >= 0; i--) begin
            if (req_valid[i]) begin
                grant     = '0;
                grant[i]  = 1'b1;
                grant_idx = IDX_W'(i);
                grant_any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
    import llsc_pkg::*;
#(
    parameter int N_AGENTS = 3,
    parameter int ADDR_W   = 4,
    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [IDX_W-1:0]  acc_idx,
    input  llsc_op_e          acc_op,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              sc_ok
);

    typedef struct packed {
        logic [N_AGENTS-1:0]             vld;
        logic [N_AGENTS-1:0][ADDR_W-1:0] addr;
    } resv_t;

    resv_t resv_d, resv_q;
    logic [N_AGENTS-1:0] hit;
    logic [N_AGENTS-1:0] self;

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_entry
        assign hit[g]  = resv_q.vld[g] && (resv_q.addr[g] == acc_addr);
        assign self[g] = (acc_idx == IDX_W'(g));
    end

    assign sc_ok = |(hit & self);

    always_comb begin
        resv_d = resv_q;
        if (acc_valid) begin
            case (acc_op)
                OP_LL: begin
                    for (int j = 0; j < N_AGENTS; j++) begin
                        if (self[j]) begin
                            resv_d.vld[j]  = 1'b1;
                            resv_d.addr[j] = acc_addr;
                        end
                    end
                end
                OP_STORE: begin
                    for (int j = 0; j < N_AGENTS; j++) begin
                        if (hit[j] && !self[j]) resv_d.vld[j] = 1'b0;
                    end
                end
                OP_SC: begin
                    for (int j = 0; j < N_AGENTS; j++) begin
                        if (self[j]) resv_d.vld[j] = 1'b0;
                        else if (sc_ok && hit[j]) resv_d.vld[j] = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resv_q <= '0;
        else        resv_q <= resv_d;
    end

endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    typedef logic [DEPTH-1:0][DATA_W-1:0] mem_t;

    mem_t mem_d, mem_q;

    assign rd_data = mem_q[rd_addr];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int N_AGENTS = 3,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_AGENTS-1:0]          req_valid,
    output logic [N_AGENTS-1:0]          req_ready,
    input  logic [2*N_AGENTS-1:0]        req_op,
    input  logic [ADDR_W*N_AGENTS-1:0]   req_addr,
    input  logic [DATA_W*N_AGENTS-1:0]   req_wdata,
    output logic [N_AGENTS-1:0]          rsp_valid,
    output logic [DATA_W-1:0]            rsp_rdata,
    output logic                         rsp_status,
    output logic                         mem_wr_en,
    output logic [ADDR_W-1:0]            mem_wr_addr,
    output logic [DATA_W-1:0]            mem_wr_data
);

    localparam int IDX_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

    typedef struct packed {
        logic [N_AGENTS-1:0] vld;
        logic [DATA_W-1:0]   rdata;
        logic                status;
    } rsp_t;

    logic [N_AGENTS-1:0] grant;
    logic [IDX_W-1:0]    grant_idx;
    logic                grant_any;
    llsc_op_e            acc_op;
    logic [ADDR_W-1:0]   acc_addr;
    logic [DATA_W-1:0]   acc_wdata;
    logic                sc_ok;
    logic [DATA_W-1:0]   rd_word;
    logic                do_write;
    rsp_t                rsp_d, rsp_q;

    llsc_arbiter #(.N_AGENTS(N_AGENTS)) u_arb (
        .req_valid (req_valid),
        .grant     (grant),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    always_comb begin
        acc_op    = OP_LOAD;
        acc_addr  = '0;
        acc_wdata = '0;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (grant[i]) begin
                acc_op    = llsc_op_e'(req_op[i*2 +: 2]);
                acc_addr  = req_addr[i*ADDR_W +: ADDR_W];
                acc_wdata = req_wdata[i*DATA_W +: DATA_W];
            end
        end
    end

    llsc_resv_table #(.N_AGENTS(N_AGENTS), .ADDR_W(ADDR_W)) u_resv (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (grant_any),
        .acc_idx   (grant_idx),
        .acc_op    (acc_op),
        .acc_addr  (acc_addr),
        .sc_ok     (sc_ok)
    );

    assign do_write = grant_any &&
                      ((acc_op == OP_STORE) || ((acc_op == OP_SC) && sc_ok));

    llsc_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (do_write),
        .wr_addr (acc_addr),
        .wr_data (acc_wdata),
        .rd_addr (acc_addr),
        .rd_data (rd_word)
    );

    always_comb begin
        rsp_d.vld    = grant;
        rsp_d.rdata  = '0;
        rsp_d.status = 1'b0;
        if (grant_any) begin
            if ((acc_op == OP_LOAD) || (acc_op == OP_LL)) rsp_d.rdata = rd_word;
            if (acc_op == OP_SC) rsp_d.status = sc_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign req_ready   = grant;
    assign rsp_valid   = rsp_q.vld;
    assign rsp_rdata   = rsp_q.rdata;
    assign rsp_status  = rsp_q.status;
    assign mem_wr_en   = do_write;
    assign mem_wr_addr = acc_addr;
    assign mem_wr_data = acc_wdata;

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int N_AGENTS = 3,
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_AGENTS-1:0]        req_valid,
    input logic [N_AGENTS-1:0]        req_ready,
    input logic [2*N_AGENTS-1:0]      req_op,
    input logic [ADDR_W*N_AGENTS-1:0] req_addr,
    input logic [N_AGENTS-1:0]        rsp_valid,
    input logic                       rsp_status,
    input logic                       mem_wr_en,
    input logic [ADDR_W-1:0]          mem_wr_addr
);

    logic              seen_acc;
    logic [1:0]        seen_op;
    logic [ADDR_W-1:0] seen_addr;

    always_comb begin
        seen_acc  = 1'b0;
        seen_op   = 2'd0;
        seen_addr = '0;
        for (int i = 0; i < N_AGENTS; i++) begin
            if (req_valid[i] && req_ready[i]) begin
                seen_acc  = 1'b1;
                seen_op   = req_op[i*2 +: 2];
                seen_addr = req_addr[i*ADDR_W +: ADDR_W];
            end
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready)); // R1
    AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0); // R1
    AST_AGENT0_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |-> req_ready[0]); // R1
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_acc |=> rsp_valid == $past(req_valid & req_ready)); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_acc |=> rsp_valid == '0); // R2
    AST_WRITE_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> seen_acc); // R3
    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_acc && (seen_op == 2'd0 || seen_op == 2'd2)) |-> !mem_wr_en); // R3
    AST_STORE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_acc && seen_op == 2'd1) |-> (mem_wr_en && mem_wr_addr == seen_addr)); // R3
    AST_SC_OK_WROTE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_acc && seen_op == 2'd3 && mem_wr_en) |=> rsp_status); // R4
    AST_SC_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_acc && seen_op == 2'd3 && !mem_wr_en) |=> !rsp_status); // R5
    AST_STATUS_SC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_acc && seen_op != 2'd3) |=> !rsp_status); // R5

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .N_AGENTS (N_AGENTS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_op      (req_op),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_status  (rsp_status),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr)
);

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;

    localparam int NA = 3;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int VW = 46;
    localparam int NV = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NA-1:0]     req_valid = '0;
    logic [NA-1:0]     req_ready;
    logic [2*NA-1:0]   req_op = '0;
    logic [AW*NA-1:0]  req_addr = '0;
    logic [DW*NA-1:0]  req_wdata = '0;
    logic [NA-1:0]     rsp_valid;
    logic [DW-1:0]     rsp_rdata;
    logic              rsp_status;
    logic              mem_wr_en;
    logic [AW-1:0]     mem_wr_addr;
    logic [DW-1:0]     mem_wr_data;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    llsc_monitor #(.N_AGENTS(NA), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_status(rsp_status),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    // op codes: 0 load, 1 store, 2 load-linked, 3 store-conditional
    // {agent[2], op[2], addr[4], wdata[16], exp_rdata[16], exp_status, exp_we, req[4]}
    localparam logic [VW-1:0] VEC [NV] = '{
        {2'd0, 2'd1, 4'h3, 16'h0011, 16'h0000, 1'b0, 1'b1, 4'd3},  // R3 plain store
        {2'd1, 2'd0, 4'h3, 16'h0000, 16'h0011, 1'b0, 1'b0, 4'd2},  // R2 load sees store
        {2'd1, 2'd2, 4'h3, 16'h0000, 16'h0011, 1'b0, 1'b0, 4'd4},  // R4 LL
        {2'd1, 2'd3, 4'h3, 16'h0022, 16'h0000, 1'b1, 1'b1, 4'd4},  // R4 SC ok
        {2'd2, 2'd0, 4'h3, 16'h0000, 16'h0022, 1'b0, 1'b0, 4'd4},  // R4 written
        {2'd1, 2'd3, 4'h3, 16'h0033, 16'h0000, 1'b0, 1'b0, 4'd8},  // R8 second SC fails
        {2'd2, 2'd0, 4'h3, 16'h0000, 16'h0022, 1'b0, 1'b0, 4'd8},  // R8 unchanged
        {2'd0, 2'd3, 4'h5, 16'h0044, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 no reservation
        {2'd0, 2'd2, 4'h5, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd4},  // R4 LL
        {2'd0, 2'd3, 4'h6, 16'h0055, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 address mismatch
        {2'd0, 2'd0, 4'h6, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd5},  // R5 untouched
        {2'd2, 2'd2, 4'h3, 16'h0000, 16'h0022, 1'b0, 1'b0, 4'd6},  // R6 LL
        {2'd0, 2'd1, 4'h3, 16'h0000, 16'h0000, 1'b0, 1'b1, 4'd6},  // R6 release store of 0
        {2'd2, 2'd3, 4'h3, 16'h0077, 16'h0000, 1'b0, 1'b0, 4'd6},  // R6 broken
        {2'd1, 2'd2, 4'h7, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd6},  // R6 LL
        {2'd0, 2'd1, 4'h8, 16'h0099, 16'h0000, 1'b0, 1'b1, 4'd6},  // R6 other address
        {2'd1, 2'd3, 4'h7, 16'h0066, 16'h0000, 1'b1, 1'b1, 4'd6},  // R6 survives
        {2'd2, 2'd2, 4'h9, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 LL
        {2'd2, 2'd2, 4'hA, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 replace
        {2'd2, 2'd3, 4'h9, 16'h0012, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 old address fails
        {2'd0, 2'd2, 4'hB, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd6},  // R6 LL
        {2'd0, 2'd1, 4'hB, 16'h00AB, 16'h0000, 1'b0, 1'b1, 4'd6},  // R6 own store
        {2'd0, 2'd3, 4'hB, 16'h00CD, 16'h0000, 1'b1, 1'b1, 4'd6},  // R6 own store harmless
        {2'd1, 2'd2, 4'hC, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7 LL
        {2'd2, 2'd2, 4'hC, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7 LL
        {2'd1, 2'd3, 4'hC, 16'h005A, 16'h0000, 1'b1, 1'b1, 4'd7},  // R7 first SC wins
        {2'd2, 2'd3, 4'hC, 16'h005B, 16'h0000, 1'b0, 1'b0, 4'd7},  // R7 loser fails
        {2'd1, 2'd0, 4'h7, 16'h0000, 16'h0066, 1'b0, 1'b0, 4'd2},  // R2 read back
        {2'd2, 2'd0, 4'hC, 16'h0000, 16'h005A, 1'b0, 1'b0, 4'd7},  // R7 read back
        {2'd0, 2'd0, 4'h8, 16'h0000, 16'h0099, 1'b0, 1'b0, 4'd3},  // R3 read back
        {2'd0, 2'd0, 4'h9, 16'h0000, 16'h0000, 1'b0, 1'b0, 4'd9},  // R9 read back
        {2'd0, 2'd0, 4'hB, 16'h0000, 16'h00CD, 1'b0, 1'b0, 4'd6}   // R6 read back
    };

    task automatic chk(input string what, input int rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input int ag, input logic [1:0] op, input logic [AW-1:0] ad,
                         input logic [DW-1:0] wd);
        req_valid[ag]           = 1'b1;
        req_op[ag*2 +: 2]       = op;
        req_addr[ag*AW +: AW]   = ad;
        req_wdata[ag*DW +: DW]  = wd;
    endtask

    task automatic issue(input int ag, input logic [1:0] op, input logic [AW-1:0] ad,
                         input logic [DW-1:0] wd, input logic [DW-1:0] erd,
                         input logic est, input logic ewe, input int rq);
        @(negedge clk);
        req_valid = '0;
        drive(ag, op, ad, wd);
        #1;
        chk("ready", 1, 32'(req_ready), 32'(NA'(1) << ag));
        chk("wr_en", rq, 32'(mem_wr_en), 32'(ewe));
        if (ewe) chk("wr_data", rq, 32'(mem_wr_data), 32'(wd));
        @(negedge clk);
        req_valid = '0;
        #1;
        chk("rsp_valid", 2, 32'(rsp_valid), 32'(NA'(1) << ag));
        chk("rdata", rq, 32'(rsp_rdata), 32'(erd));
        chk("status", rq, 32'(rsp_status), 32'(est));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("reset rsp_valid", 11, 32'(rsp_valid), 32'd0);  // R11
        chk("reset wr_en", 11, 32'(mem_wr_en), 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            issue(int'(VEC[v][45:44]), VEC[v][43:42], VEC[v][41:38], VEC[v][37:22],
                  VEC[v][21:6], VEC[v][5], VEC[v][4], int'(VEC[v][3:0]));
        end

        // R1 / R7: simultaneous store-conditionals, lower index first
        issue(0, 2'd2, 4'hD, 16'h0, 16'h0, 1'b0, 1'b0, 7);
        issue(1, 2'd2, 4'hD, 16'h0, 16'h0, 1'b0, 1'b0, 7);
        @(negedge clk);
        drive(0, 2'd3, 4'hD, 16'h0001);
        drive(1, 2'd3, 4'hD, 16'h0002);
        #1;
        chk("R1 ready both valid", 1, 32'(req_ready), 32'b001);
        chk("R7 winner write", 7, 32'(mem_wr_data), 32'h0001);
        @(negedge clk);
        req_valid[0] = 1'b0;
        #1;
        chk("R7 winner status", 7, 32'(rsp_status), 32'd1);
        chk("R2 winner rsp", 2, 32'(rsp_valid), 32'b001);
        chk("R1 waiter ready", 1, 32'(req_ready), 32'b010);
        chk("R7 loser no write", 7, 32'(mem_wr_en), 32'd0);
        @(negedge clk);
        req_valid = '0;
        #1;
        chk("R7 loser rsp", 2, 32'(rsp_valid), 32'b010);
        chk("R7 loser status", 7, 32'(rsp_status), 32'd0);
        issue(2, 2'd0, 4'hD, 16'h0, 16'h0001, 1'b0, 1'b0, 7);

        // R10: reservation held across a long gap with foreign loads
        issue(0, 2'd2, 4'hE, 16'h0, 16'h0, 1'b0, 1'b0, 10);
        for (int k = 0; k < 20; k++) begin
            repeat (25) @(negedge clk);
            issue(1, 2'd0, 4'hE, 16'h0, 16'h0, 1'b0, 1'b0, 10);
        end
        issue(0, 2'd3, 4'hE, 16'h003C, 16'h0, 1'b1, 1'b1, 10);

        // R11: reset clears memory and reservations
        issue(2, 2'd2, 4'h1, 16'h0, 16'h0, 1'b0, 1'b0, 11);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R11 rsp_valid in reset", 11, 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        issue(0, 2'd0, 4'hC, 16'h0, 16'h0, 1'b0, 1'b0, 11);
        issue(0, 2'd0, 4'hE, 16'h0, 16'h0, 1'b0, 1'b0, 11);
        issue(2, 2'd3, 4'h1, 16'h0044, 16'h0, 1'b0, 1'b0, 11);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule